// File: doc/BRIEF.md
# Pseudo-SRAM power sequencer

This block takes charge of the high-active chip-enable (CE2) of a pseudo-SRAM and holds the low-active chip-enable (CE1) at its idle high level while it has control. After reset it waits for a supply-good input. It then runs one of three start-up methods, chosen by a parameter, and raises `ready_o` once the memory may be used. While `ready_o` is low, `ovr_o` tells the access controller that the sequencer owns both enables.

Later, a deep power-down can be requested. The request is honoured only once the access controller has reported idle for a standby margin. CE2 then drops after a CE1 setup time and stays low for at least a minimum time. A wake request leaves power-down, and the long post-exit hold runs before `ready_o` returns.

Every delay is given in nanoseconds and converted to clock cycles from the clock-period parameter.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset, and while `supply_ok_i` is low, `ready_o`=0, `ovr_o`=1 and `ce1_o`=1. `ce2_o` is 0 for method 1 and 1 for methods 2 and 3.
- R2: Method 1 (PU_METHOD=1). Once supply is good, CE2 stays low for N_PU cycles and then rises. CE1 is held high for N_EX more cycles, after which `ready_o` rises.
- R3: Method 2. CE2 is held high for N_PU cycles. A power-down follows with CE1 high for N_SU cycles, then CE2 low for exactly N_LO cycles, entered and left without a wake request. The N_EX exit hold then runs before `ready_o` rises.
- R4: Method 3. CE1 and CE2 stay high for N_PU3 cycles, then `ready_o` rises. CE1 is never driven low during any start-up method.
- R5: Each delay N = ceil(ns*1000 / CLK_PERIOD_PS), with a minimum of 1. For example, 36 ns at 8000 ps gives 5 cycles.
- R6: A power-down request in the ready state starts entry only on the edge after `ctrl_idle_i` has been high for N_ST consecutive sampled edges. Any busy cycle restarts that count.
- R7: On entry, `ready_o` falls and `ovr_o` rises. CE2 stays high for N_SU cycles with CE1 high, then falls.
- R8: CE2 stays low for at least N_LO cycles. It rises on the edge after `wake_req_i` is seen high once that minimum has passed, and `ready_o` rises N_EX cycles after CE2 rises.
- R9: `wake_req_i` has no effect outside power-down, and `pd_req_i` has no effect outside the ready state.
- R10: `supply_ok_i` low at any clock edge returns the block to its R1 waiting state on that edge.
- R11: In the ready state, `ovr_o`=0 and `ce2_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| supply_ok_i | input | 1 | supply has reached its working minimum |
| pd_req_i | input | 1 | request to enter deep power-down (level) |
| wake_req_i | input | 1 | request to leave deep power-down (level) |
| ctrl_idle_i | input | 1 | access controller idle with CE1 high |
| ce1_o | output | 1 | CE1 level while `ovr_o` is high |
| ce2_o | output | 1 | CE2 pin level |
| ovr_o | output | 1 | sequencer owns the enables |
| ready_o | output | 1 | memory usable by the access controller |

## Verification
All outputs are decoded from registered state, so each result appears on the first edge at which its condition holds. For a stimulus applied in cycle 0, a phase of N cycles is visible from sample N+1. Boot therefore completes at sample 1+N_PU+N_EX for method 1, 1+N_PU+N_SU+N_LO+N_EX for method 2 and 1+N_PU3 for method 3. A power-down request completes N_ST+1 samples after idle settles. The bench drives inputs on the falling edge and samples on the next falling edges at those computed indices, including the sample one before each due cycle. Idle-glitch offsets 0 to 3 are swept, alternating an early wake with a late one, so that both the minimum-low bound and the wake-triggered exit are checked.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;
  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_BOOT  = 3'd1,
    ST_EXIT  = 3'd2,
    ST_READY = 3'd3,
    ST_PREP  = 3'd4,
    ST_PD    = 3'd5
  } pwr_state_e;

  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned period_ps);
    longint unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_tmr_stays_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && done_o) |=> done_o);
endmodule

// File: rtl/psram_idle_track.sv
module psram_idle_track #(
  parameter int unsigned N_ST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic idle_i,
  input  logic req_i,
  output logic go_o
);
  localparam int unsigned W = $clog2(N_ST + 1);
  localparam logic [W-1:0] LIM = W'(N_ST);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || !idle_i)    cnt_q <= '0;
    else if (cnt_q != LIM)        cnt_q <= cnt_q + 1'b1;
  end

  assign go_o = en_i && req_i && idle_i && (cnt_q == LIM);

  // idle margin must already have been observed on earlier edges
  assert_go_after_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(idle_i) && $past(en_i));
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pwr_pkg::*;
#(
  parameter int unsigned PU_METHOD = 1,
  parameter int unsigned N_PU      = 2,
  parameter int unsigned N_PU3     = 2,
  parameter int unsigned N_SU      = 1,
  parameter int unsigned N_LO      = 1,
  parameter int unsigned N_EX      = 2,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             pd_go_i,
  input  logic             wake_req_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             in_ready_o,
  output logic             ce2_o,
  output logic             ovr_o
);
  localparam logic CE2_BOOT = (PU_METHOD != 1);
  localparam int unsigned N_BOOT = (PU_METHOD == 3) ? N_PU3 : N_PU;

  pwr_state_e state_q, state_d;
  logic       boot_q;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT:  state_d = ST_BOOT;
        ST_BOOT:  if (tmr_done_i) begin
                    if (PU_METHOD == 1)      state_d = ST_EXIT;
                    else if (PU_METHOD == 2) state_d = ST_PREP;
                    else                     state_d = ST_READY;
                  end
        ST_EXIT:  if (tmr_done_i) state_d = ST_READY;
        ST_READY: if (pd_go_i) state_d = ST_PREP;
        ST_PREP:  if (tmr_done_i) state_d = ST_PD;
        ST_PD:    if (tmr_done_i && (wake_req_i || boot_q)) state_d = ST_EXIT;
        default:  state_d = ST_WAIT;
      endcase
    end
  end

  always_comb begin
    unique case (state_d)
      ST_BOOT: tmr_val_o = CNT_W'(N_BOOT - 1);
      ST_EXIT: tmr_val_o = CNT_W'(N_EX - 1);
      ST_PREP: tmr_val_o = CNT_W'(N_SU - 1);
      ST_PD:   tmr_val_o = CNT_W'(N_LO - 1);
      default: tmr_val_o = '0;
    endcase
  end

  assign tmr_load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      boot_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_d == ST_WAIT)       boot_q <= 1'b1;
      else if (state_d == ST_READY) boot_q <= 1'b0;
    end
  end

  assign in_ready_o = (state_q == ST_READY);
  assign ovr_o      = (state_q != ST_READY);
  always_comb begin
    unique case (state_q)
      ST_WAIT, ST_BOOT: ce2_o = CE2_BOOT;
      ST_PD:            ce2_o = 1'b0;
      default:          ce2_o = 1'b1;
    endcase
  end

  assert_pd_min_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD && state_d == ST_EXIT) |-> tmr_done_i);
  assert_setup_before_pd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREP && state_d == ST_PD) |-> tmr_done_i);
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned PU_METHOD     = 1,
  parameter int unsigned T_PU_NS       = 50000,
  parameter int unsigned T_PU3_NS      = 400000,
  parameter int unsigned T_EXIT_NS     = 350000,
  parameter int unsigned T_SETUP_NS    = 10,
  parameter int unsigned T_LOW_NS      = 80,
  parameter int unsigned T_STBY_NS     = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic pd_req_i,
  input  logic wake_req_i,
  input  logic ctrl_idle_i,
  output logic ce1_o,
  output logic ce2_o,
  output logic ovr_o,
  output logic ready_o
);
  localparam int unsigned N_PU  = ns_to_cyc(T_PU_NS,    CLK_PERIOD_PS);
  localparam int unsigned N_PU3 = ns_to_cyc(T_PU3_NS,   CLK_PERIOD_PS);
  localparam int unsigned N_EX  = ns_to_cyc(T_EXIT_NS,  CLK_PERIOD_PS);
  localparam int unsigned N_SU  = ns_to_cyc(T_SETUP_NS, CLK_PERIOD_PS);
  localparam int unsigned N_LO  = ns_to_cyc(T_LOW_NS,   CLK_PERIOD_PS);
  localparam int unsigned N_ST  = ns_to_cyc(T_STBY_NS,  CLK_PERIOD_PS);
  localparam int unsigned N_MAX_A = (N_PU  > N_PU3) ? N_PU  : N_PU3;
  localparam int unsigned N_MAX_B = (N_EX  > N_SU)  ? N_EX  : N_SU;
  localparam int unsigned N_MAX_C = (N_MAX_A > N_MAX_B) ? N_MAX_A : N_MAX_B;
  localparam int unsigned N_MAX   = (N_MAX_C > N_LO) ? N_MAX_C : N_LO;
  localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

  logic             tmr_load, tmr_done, in_ready, pd_go;
  logic [CNT_W-1:0] tmr_val;

  generate
    if (PU_METHOD < 1 || PU_METHOD > 3) begin : g_bad_method
      initial assert_method_range_R1: assert (0) else $error("PU_METHOD out of range");
    end
  endgenerate

  psram_pwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  psram_idle_track #(.N_ST(N_ST)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_ready),
    .idle_i (ctrl_idle_i),
    .req_i  (pd_req_i),
    .go_o   (pd_go)
  );

  psram_pwr_fsm #(
    .PU_METHOD (PU_METHOD),
    .N_PU      (N_PU),
    .N_PU3     (N_PU3),
    .N_SU      (N_SU),
    .N_LO      (N_LO),
    .N_EX      (N_EX),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .pd_go_i     (pd_go),
    .wake_req_i  (wake_req_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .in_ready_o  (in_ready),
    .ce2_o       (ce2_o),
    .ovr_o       (ovr_o)
  );

  // CE1 idle level; the access controller drives CE1 whenever ovr_o is low
  assign ce1_o   = 1'b1;
  assign ready_o = in_ready;

  assert_pd_from_override_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce2_o) && supply_ok_i) |-> ($past(ovr_o) && !$past(ready_o)));
  assert_ready_after_ce2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(ce2_o) && ce2_o));
  assert_supply_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !ready_o && ovr_o);
endmodule

// File: tb/sim_psram_pwr_seq.sv
module sim_psram_pwr_seq;
  localparam int unsigned P_PS = 8000;
  localparam int unsigned T_PU = 56, T_PU3 = 96, T_EX = 80, T_SU = 16, T_LO = 36, T_ST = 24;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + P_PS - 1) / P_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_PU = (T_PU * 1000 + P_PS - 1) / P_PS;
  int n_pu, n_pu3, n_ex, n_su, n_lo, n_st;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic supply_ok = 1'b0, pd_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b0;
  logic [2:0] rdy, ovr, c1, c2;
  int errors = 0, checks = 0, cycles = 0;

  always #4 clk_i = ~clk_i;

  psram_pwr_seq #(.CLK_PERIOD_PS(P_PS), .PU_METHOD(1), .T_PU_NS(T_PU), .T_PU3_NS(T_PU3),
    .T_EXIT_NS(T_EX), .T_SETUP_NS(T_SU), .T_LOW_NS(T_LO), .T_STBY_NS(T_ST)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .pd_req_i(pd_req),
    .wake_req_i(wake_req), .ctrl_idle_i(ctrl_idle),
    .ce1_o(c1[0]), .ce2_o(c2[0]), .ovr_o(ovr[0]), .ready_o(rdy[0]));
  psram_pwr_seq #(.CLK_PERIOD_PS(P_PS), .PU_METHOD(2), .T_PU_NS(T_PU), .T_PU3_NS(T_PU3),
    .T_EXIT_NS(T_EX), .T_SETUP_NS(T_SU), .T_LOW_NS(T_LO), .T_STBY_NS(T_ST)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .pd_req_i(pd_req),
    .wake_req_i(wake_req), .ctrl_idle_i(ctrl_idle),
    .ce1_o(c1[1]), .ce2_o(c2[1]), .ovr_o(ovr[1]), .ready_o(rdy[1]));
  psram_pwr_seq #(.CLK_PERIOD_PS(P_PS), .PU_METHOD(3), .T_PU_NS(T_PU), .T_PU3_NS(T_PU3),
    .T_EXIT_NS(T_EX), .T_SETUP_NS(T_SU), .T_LOW_NS(T_LO), .T_STBY_NS(T_ST)) u2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .pd_req_i(pd_req),
    .wake_req_i(wake_req), .ctrl_idle_i(ctrl_idle),
    .ce1_o(c1[2]), .ce2_o(c2[2]), .ovr_o(ovr[2]), .ready_o(rdy[2]));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      summary();
    end
  end

  // wait-state levels per method (R1/R10)
  task automatic chk_wait(input string tag);
    for (int k = 0; k < 3; k++) begin
      chk({tag, " ready"}, int'(rdy[k]), 0);
      chk({tag, " ovr"}, int'(ovr[k]), 1);
      chk({tag, " ce1"}, int'(c1[k]), 1);
      chk({tag, " ce2"}, int'(c2[k]), (k == 0) ? 0 : 1);
    end
  endtask

  task automatic chk_all(input string tag, input logic [2:0] v, input logic [2:0] e);
    chk(tag, int'(v), int'(e));
  endtask

  initial begin
    int first_rdy [3];
    int first_hi0, first_lo1, lo_cnt1, ce1_bad, early;
    n_pu = cyc(T_PU); n_pu3 = cyc(T_PU3); n_ex = cyc(T_EX);
    n_su = cyc(T_SU); n_lo = cyc(T_LO); n_st = cyc(T_ST);
    chk("R5 36ns rounds up to 5 cycles", n_lo, 5);
    chk("R5 bench constant", N_PU, n_pu);

    repeat (3) @(negedge clk_i);
    chk_wait("R1 in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_wait("R1 no supply");

    // boot: pd/wake held during start-up must be ignored (R9)
    supply_ok = 1'b1; pd_req = 1'b1; wake_req = 1'b1; ctrl_idle = 1'b1;
    first_rdy = '{0, 0, 0}; first_hi0 = 0; first_lo1 = 0; lo_cnt1 = 0; ce1_bad = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk_i);
      for (int k = 0; k < 3; k++) begin
        if (rdy[k] && first_rdy[k] == 0) first_rdy[k] = i;
        if (!c1[k]) ce1_bad++;
      end
      if (c2[0] && first_hi0 == 0) first_hi0 = i;
      if (!c2[1]) begin
        lo_cnt1++;
        if (first_lo1 == 0) first_lo1 = i;
      end
      if (i == 10) begin pd_req = 1'b0; wake_req = 1'b0; end
    end
    chk("R2 method1 ce2 rises", first_hi0, n_pu + 1);
    chk("R2 method1 ready", first_rdy[0], n_pu + n_ex + 1);
    chk("R3 method2 ce2 falls", first_lo1, n_pu + n_su + 1);
    chk("R3 method2 ce2 low cycles", lo_cnt1, n_lo);
    chk("R3 R9 method2 ready", first_rdy[1], n_pu + n_su + n_lo + n_ex + 1);
    chk("R4 R9 method3 ready", first_rdy[2], n_pu3 + 1);
    chk("R4 ce1 never low during boot", ce1_bad, 0);
    chk_all("R11 ready idle ovr", ovr, 3'b000);
    chk_all("R11 ready idle ce2", c2, 3'b111);

    // wake in ready state is ignored (R9)
    wake_req = 1'b1;
    repeat (5) @(negedge clk_i);
    chk_all("R9 wake ignored ready", rdy, 3'b111);
    chk_all("R9 wake ignored ce2", c2, 3'b111);
    wake_req = 1'b0;

    // busy controller holds off the request (R6)
    ctrl_idle = 1'b0; pd_req = 1'b1;
    repeat (8) @(negedge clk_i);
    chk_all("R6 busy blocks entry", rdy, 3'b111);

    // sweep idle glitch offsets; alternate early and late wake
    for (int g = 0; g <= 3; g++) begin
      ctrl_idle = 1'b0; pd_req = 1'b1;
      @(negedge clk_i);
      ctrl_idle = 1'b1;
      early = 0;
      for (int j = 1; j <= g; j++) begin
        @(negedge clk_i);
        if (rdy != 3'b111) early++;
      end
      ctrl_idle = 1'b0;
      @(negedge clk_i);
      if (rdy != 3'b111) early++;
      chk("R6 glitch restarts count", early, 0);
      ctrl_idle = 1'b1;
      for (int j = 1; j <= 40; j++) begin
        @(negedge clk_i);
        if (j == n_st)     chk_all("R6 not yet entered", rdy, 3'b111);
        if (j == n_st + 1) begin
          chk_all("R6 R7 entry ready", rdy, 3'b000);
          chk_all("R7 entry ovr", ovr, 3'b111);
          chk_all("R7 entry ce2 high", c2, 3'b111);
          chk_all("R7 entry ce1 high", c1, 3'b111);
          pd_req = 1'b0;
        end
        if (j == n_st + n_su)     chk_all("R7 ce2 setup", c2, 3'b111);
        if (j == n_st + n_su + 1) begin
          chk_all("R7 ce2 falls", c2, 3'b000);
          if (g % 2 == 0) wake_req = 1'b1;
        end
        if (g % 2 == 0) begin
          if (j == n_st + n_su + n_lo)     chk_all("R8 min low held", c2, 3'b000);
          if (j == n_st + n_su + n_lo + 1) chk_all("R8 early wake exit", c2, 3'b111);
          if (j == n_st + n_su + n_lo + n_ex) chk_all("R8 exit hold", rdy, 3'b000);
          if (j == n_st + n_su + n_lo + n_ex + 1) chk_all("R8 ready back", rdy, 3'b111);
        end else begin
          if (j == 20) begin
            chk_all("R8 no wake stays down", c2, 3'b000);
            wake_req = 1'b1;
          end
          if (j == 21)        chk_all("R8 late wake exit", c2, 3'b111);
          if (j == 20 + n_ex) chk_all("R8 late exit hold", rdy, 3'b000);
          if (j == 21 + n_ex) chk_all("R8 late ready back", rdy, 3'b111);
        end
      end
      wake_req = 1'b0;
    end

    // supply loss in ready state
    supply_ok = 1'b0;
    @(negedge clk_i);
    chk_wait("R10 supply lost");
    summary();
  end
endmodule